// File: doc/BRIEF.md
# CPU Interrupt Pending and Gating Unit

This block keeps the interrupt state of a single CPU thread and decides, each cycle, whether the core should take an interrupt. It holds an eight-level pending field. Command inputs can set one level, clear one level, or wipe the whole field. A free-running count register is compared with a writable compare register. A nonzero match raises a timer interrupt on a pending level that software selects. A status register holds a global enable, two exception-state inhibit bits and an eight-bit mask. A registered take output fires when the gating allows it and a pending level is unmasked.

Software reaches the state through a single-cycle register port. A write is captured at the clock edge, and reads are combinational. Register addresses are: 0 status, 1 pending (read-only, bits [7:0]), 2 count, 3 compare, 4 timer control (bits [2:0] give the timer level). Any other address reads zero. In the status word, bit 0 is the global enable, bit 1 is the exception-level inhibit, bit 2 is the error-level inhibit and bits [15:8] are the mask.

Top module: `irq_gate_unit`

## Requirements
- R1: A set or clear command whose 4-bit index is 8 or more leaves the pending field unchanged and raises `cmd_err` for one cycle, visible after the next clock edge.
- R2: A set command for level n (0 to 7) makes pending bit n 1 after the next edge and keeps every other bit as it was.
- R3: A clear command for level n makes pending bit n 0 after the next edge and keeps every other bit as it was.
- R4: A clear-all command zeroes the whole pending field, except that a set command in the same cycle still sets its bit.
- R5: When a set and a clear name the same level in one cycle, that bit ends up set.
- R6: `take_irq` can only be 1 when, on the previous edge, status bit 0 was 1 and status bits 1 and 2 were both 0. It is registered, so it rises one cycle after the status and pending state allow it.
- R7: When the gating of R6 holds, `take_irq` is 1 exactly when some pending bit is set and its mask bit (status bit 8+n) is also set.
- R8: When count equals compare and count is nonzero, the pending bit named by timer-control bits [2:0] is set on the next edge.
- R9: A count/compare match while count is zero does not set any pending bit.
- R10: The count register (address 2) increases by one every clock and wraps from all-ones to zero. A write loads the written value instead.
- R11: A write to the compare register clears the pending bit named by the timer-control field and keeps the other pending bits.
- R12: `irq_pending` is 1 exactly when the stored pending field is nonzero.
- R13: After reset the pending field, mask, enable, count, compare and timer field are zero, both inhibit bits are 1 (status reads 0x6), and `take_irq` and `cmd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| post_valid | input | 1 | Set one pending level |
| post_idx | input | 4 | Level to set |
| clr_valid | input | 1 | Clear one pending level |
| clr_idx | input | 4 | Level to clear |
| clr_all | input | 1 | Clear the whole pending field |
| cmd_err | output | 1 | Out-of-range command seen on the previous edge |
| irq_pending | output | 1 | Any pending level set |
| take_irq | output | 1 | Core should take an interrupt |

## Verification
The set, clear and clear-all commands are driven one at a time and in conflicting pairs. This separates the per-bit update from the precedence rules and from out-of-range rejection. The gate is tried with all inhibit combinations and with mask patterns that do and do not overlap the pending bits. These show whether each gating term and the mask test act on their own, and whether the take output waits one register stage. Timer cases place the count a known number of cycles before the compare value, so the pending bit must appear on one exact edge. Further cases let the count wrap through zero onto a zero compare value, and write the compare register to acknowledge the timer bit while other pending bits stay set.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    RA_STATUS  = 3'd0,
    RA_PEND    = 3'd1,
    RA_COUNT   = 3'd2,
    RA_COMPARE = 3'd3,
    RA_TCTL    = 3'd4
  } reg_addr_e;

  // status word field positions
  localparam int ST_EN_BIT   = 0;
  localparam int ST_EXC_BIT  = 1;
  localparam int ST_ERR_BIT  = 2;
  localparam int ST_MASK_LSB = 8;

  // gating rule: enable set and neither inhibit set
  function automatic logic gate_open(logic en, logic exc, logic err);
    return en & ~exc & ~err;
  endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int LEVELS = 8,
  parameter int IDX_W  = 4,
  localparam int POS_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  input  logic [IDX_W-1:0]  post_idx,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              clr_all,
  input  logic              timer_hit,
  input  logic              timer_ack,
  input  logic [POS_W-1:0]  timer_pos,
  output logic [LEVELS-1:0] pend_q,
  output logic              cmd_err
);

  localparam logic [IDX_W:0] LIM = LEVELS[IDX_W:0];

  function automatic logic in_range(logic [IDX_W-1:0] idx);
    return {1'b0, idx} < LIM;
  endfunction

  logic              post_ok, clr_ok, err_d;
  logic [LEVELS-1:0] pend_d;

  assign post_ok = post_valid & in_range(post_idx);
  assign clr_ok  = clr_valid & in_range(clr_idx);
  assign err_d   = (post_valid & ~post_ok) | (clr_valid & ~clr_ok);

  // clears first, sets last: a set always wins
  always_comb begin
    pend_d = pend_q;
    if (clr_all)   pend_d = '0;
    if (clr_ok)    pend_d[clr_idx[POS_W-1:0]] = 1'b0;
    if (timer_ack) pend_d[timer_pos] = 1'b0;
    if (post_ok)   pend_d[post_idx[POS_W-1:0]] = 1'b1;
    if (timer_hit) pend_d[timer_pos] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      cmd_err <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      cmd_err <= err_d;
    end
  end

  // R1
  range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !post_ok && !clr_valid && !clr_all && !timer_hit && !timer_ack)
      |=> ($stable(pend_q) && cmd_err));

  // R2
  post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_ok |=> pend_q[$past(post_idx[POS_W-1:0])]);

  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !post_ok && !timer_hit) |=> (pend_q == '0));

  // R8
  timer_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_hit |=> pend_q[$past(timer_pos)]);

endmodule

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] compare_q,
  output logic             timer_hit
);

  // a match only counts away from zero
  function automatic logic match_fires(logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] cmp);
    return (cnt == cmp) && (cnt != '0);
  endfunction

  assign timer_hit = match_fires(count_q, compare_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      compare_q <= '0;
    end else begin
      count_q <= cnt_we ? wdata : count_q + 1'b1;
      if (cmp_we) compare_q <= wdata;
    end
  end

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (count_q == $past(count_q) + 1'b1));

  // R10
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count_q == $past(wdata)));

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int LEVELS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              exc_lvl,
  input  logic              err_lvl,
  input  logic [LEVELS-1:0] mask,
  input  logic [LEVELS-1:0] pend,
  output logic              take_irq
);
  import irq_pkg::*;

  logic gate_ok, hit_any;

  assign gate_ok = gate_open(gen_en, exc_lvl, err_lvl);
  assign hit_any = |(mask & pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) take_irq <= 1'b0;
    else        take_irq <= gate_ok & hit_any;
  end

  // R6
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en || exc_lvl || err_lvl) |=> !take_irq);

  // R7
  masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask & pend) == '0) |=> !take_irq);

  // R7
  take_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !exc_lvl && !err_lvl && ((mask & pend) != '0)) |=> take_irq);

endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit #(
  parameter int LEVELS = 8,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3,
  localparam int POS_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              post_valid,
  input  logic [IDX_W-1:0]  post_idx,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              clr_all,
  output logic              cmd_err,
  output logic              irq_pending,
  output logic              take_irq
);
  import irq_pkg::*;

  logic              gen_en_q, exc_q, err_q;
  logic [LEVELS-1:0] mask_q, pend_q;
  logic [POS_W-1:0]  tpos_q;
  logic [CNT_W-1:0]  count_q, compare_q;
  logic              timer_hit;
  logic              wr_status, wr_count, wr_compare, wr_tctl;

  assign wr_status  = reg_we && (reg_addr == RA_STATUS);
  assign wr_count   = reg_we && (reg_addr == RA_COUNT);
  assign wr_compare = reg_we && (reg_addr == RA_COMPARE);
  assign wr_tctl    = reg_we && (reg_addr == RA_TCTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en_q <= 1'b0;
      exc_q    <= 1'b1;
      err_q    <= 1'b1;
      mask_q   <= '0;
      tpos_q   <= '0;
    end else begin
      if (wr_status) begin
        gen_en_q <= reg_wdata[ST_EN_BIT];
        exc_q    <= reg_wdata[ST_EXC_BIT];
        err_q    <= reg_wdata[ST_ERR_BIT];
        mask_q   <= reg_wdata[ST_MASK_LSB +: LEVELS];
      end
      if (wr_tctl) tpos_q <= reg_wdata[POS_W-1:0];
    end
  end

  irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_we    (wr_count),
    .cmp_we    (wr_compare),
    .wdata     (reg_wdata),
    .count_q   (count_q),
    .compare_q (compare_q),
    .timer_hit (timer_hit)
  );

  irq_pend_reg #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .post_valid (post_valid),
    .post_idx   (post_idx),
    .clr_valid  (clr_valid),
    .clr_idx    (clr_idx),
    .clr_all    (clr_all),
    .timer_hit  (timer_hit),
    .timer_ack  (wr_compare),
    .timer_pos  (tpos_q),
    .pend_q     (pend_q),
    .cmd_err    (cmd_err)
  );

  irq_gate #(.LEVELS(LEVELS)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_en   (gen_en_q),
    .exc_lvl  (exc_q),
    .err_lvl  (err_q),
    .mask     (mask_q),
    .pend     (pend_q),
    .take_irq (take_irq)
  );

  assign irq_pending = |pend_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STATUS: begin
        reg_rdata[ST_EN_BIT]               = gen_en_q;
        reg_rdata[ST_EXC_BIT]              = exc_q;
        reg_rdata[ST_ERR_BIT]              = err_q;
        reg_rdata[ST_MASK_LSB +: LEVELS]   = mask_q;
      end
      RA_PEND:    reg_rdata[LEVELS-1:0] = pend_q;
      RA_COUNT:   reg_rdata = count_q;
      RA_COMPARE: reg_rdata = compare_q;
      RA_TCTL:    reg_rdata[POS_W-1:0] = tpos_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R11
  compare_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_compare && !timer_hit && !(post_valid && post_idx == {1'b0, tpos_q}))
      |=> !pend_q[$past(tpos_q)]);

  // R9
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !post_valid && !reg_we) |=> $stable(pend_q) || $past(clr_all || clr_valid));

endmodule

// File: tb/irq_gate_unit_bench.sv
module irq_gate_unit_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        post_valid = 1'b0;
  logic [3:0]  post_idx = '0;
  logic        clr_valid = 1'b0;
  logic [3:0]  clr_idx = '0;
  logic        clr_all = 1'b0;
  logic        cmd_err, irq_pending, take_irq;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  irq_gate_unit u_irq_gate_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .post_valid(post_valid),
    .post_idx(post_idx), .clr_valid(clr_valid), .clr_idx(clr_idx),
    .clr_all(clr_all), .cmd_err(cmd_err), .irq_pending(irq_pending),
    .take_irq(take_irq)
  );

  localparam logic [2:0] A_STATUS = 3'd0, A_PEND = 3'd1, A_COUNT = 3'd2,
                         A_COMPARE = 3'd3, A_TCTL = 3'd4;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cmd(logic pv, logic [3:0] pi, logic cv, logic [3:0] ci, logic ca);
    @(negedge clk);
    post_valid = pv; post_idx = pi; clr_valid = cv; clr_idx = ci; clr_all = ca;
    @(negedge clk);
    post_valid = 1'b0; clr_valid = 1'b0; clr_all = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_STATUS, v); chk("R13 status", v, 32'h6);
    rd(A_PEND, v);   chk("R13 pend", v, 32'h0);
    rd(A_TCTL, v);   chk("R13 tctl", v, 32'h0);
    rd(A_COMPARE, v); chk("R13 compare", v, 32'h0);
    chk("R13 take", {31'b0, take_irq}, 32'h0);
    chk("R13 err", {31'b0, cmd_err}, 32'h0);
    chk("R12 pending idle", {31'b0, irq_pending}, 32'h0);
  endtask

  task automatic t_post_clear();
    logic [31:0] v;
    cmd(1, 4'd1, 0, 0, 0);
    cmd(1, 4'd3, 0, 0, 0);
    rd(A_PEND, v); chk("R2 post 1,3", v, 32'h0A);
    chk("R12 pending set", {31'b0, irq_pending}, 32'h1);
    cmd(1, 4'd7, 0, 0, 0);
    rd(A_PEND, v); chk("R2 post 7", v, 32'h8A);
    cmd(0, 0, 1, 4'd1, 0);
    rd(A_PEND, v); chk("R3 clear 1", v, 32'h88);
  endtask

  task automatic t_range();
    logic [31:0] v;
    cmd(1, 4'd9, 0, 0, 0);
    chk("R1 post err", {31'b0, cmd_err}, 32'h1);
    rd(A_PEND, v); chk("R1 post ignored", v, 32'h88);
    cmd(0, 0, 1, 4'd15, 0);
    chk("R1 clear err", {31'b0, cmd_err}, 32'h1);
    rd(A_PEND, v); chk("R1 clear ignored", v, 32'h88);
    step(1);
    chk("R1 err drops", {31'b0, cmd_err}, 32'h0);
  endtask

  task automatic t_clrall();
    logic [31:0] v;
    cmd(1, 4'd2, 0, 0, 1);
    rd(A_PEND, v); chk("R4 clear-all with post", v, 32'h04);
    cmd(0, 0, 0, 0, 1);
    rd(A_PEND, v); chk("R4 clear-all", v, 32'h00);
    chk("R12 pending cleared", {31'b0, irq_pending}, 32'h0);
  endtask

  task automatic t_conflict();
    logic [31:0] v;
    cmd(1, 4'd6, 1, 4'd6, 0);
    rd(A_PEND, v); chk("R5 post beats clear", v, 32'h40);
    cmd(0, 0, 0, 0, 1);
  endtask

  task automatic t_gate();
    cmd(1, 4'd3, 0, 0, 0);
    wr(A_STATUS, 32'h0000_0801);
    chk("R6 registered latency", {31'b0, take_irq}, 32'h0);
    step(1);
    chk("R7 take unmasked", {31'b0, take_irq}, 32'h1);
    wr(A_STATUS, 32'h0000_0803); step(1);
    chk("R6 exc inhibit", {31'b0, take_irq}, 32'h0);
    wr(A_STATUS, 32'h0000_0805); step(1);
    chk("R6 err inhibit", {31'b0, take_irq}, 32'h0);
    wr(A_STATUS, 32'h0000_0800); step(1);
    chk("R6 enable off", {31'b0, take_irq}, 32'h0);
    wr(A_STATUS, 32'h0000_1001); step(1);
    chk("R7 mask miss", {31'b0, take_irq}, 32'h0);
    cmd(1, 4'd4, 0, 0, 0); step(1);
    chk("R7 mask hit", {31'b0, take_irq}, 32'h1);
    wr(A_STATUS, 32'h0000_0006);
    cmd(0, 0, 0, 0, 1);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    wr(A_TCTL, 32'd5);
    wr(A_COMPARE, 32'd20);
    wr(A_COUNT, 32'd15);
    rd(A_COUNT, v); chk("R10 count load", v, 32'd15);
    step(1);
    rd(A_COUNT, v); chk("R10 count step", v, 32'd16);
    step(4);
    chk("R8 no early hit", {31'b0, irq_pending}, 32'h0);
    step(1);
    rd(A_PEND, v); chk("R8 timer level 5", v, 32'h20);
    chk("R12 pending from timer", {31'b0, irq_pending}, 32'h1);
  endtask

  task automatic t_compare_ack();
    logic [31:0] v;
    cmd(1, 4'd2, 0, 0, 0);
    wr(A_COMPARE, 32'hFFFF_0000);
    rd(A_PEND, v); chk("R11 compare write ack", v, 32'h04);
    cmd(0, 0, 0, 0, 1);
  endtask

  task automatic t_timer_zero();
    logic [31:0] v;
    wr(A_COMPARE, 32'h0);
    wr(A_COUNT, 32'hFFFF_FFFE);
    step(1);
    rd(A_COUNT, v); chk("R10 count max", v, 32'hFFFF_FFFF);
    step(1);
    rd(A_COUNT, v); chk("R10 count wrap", v, 32'h0);
    step(3);
    rd(A_PEND, v); chk("R9 zero match quiet", v, 32'h0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_post_clear();
    t_range();
    t_clrall();
    t_conflict();
    t_gate();
    t_timer();
    t_compare_ack();
    t_timer_zero();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule